// File: doc/BRIEF.md
# Power-of-Two Oversampling Averager

This block sits between a 10-bit converter and the per-sequence result stores. A 3-bit exponent sets how many raw conversions of one step are combined. The block sums 2^exponent raw samples, then emits one result equal to the sum shifted right by the exponent, with any remainder dropped. The result is tagged with the sequencer and step numbers that were present on the first sample of the group.

For every raw sample that does not close a group, the block pulses a repeat request so that the step controller converts the same input again. The sample that closes a group produces the result pulse instead, and that pulse also tells the controller that the step is finished. With an exponent of 0, which is the reset value a controller would normally program, every raw sample is passed through unchanged. One exponent applies to all steps. The exponent and the context tag are latched on the first sample of each group, so a change made part way through a group only affects the next group.

Top module: `oversample_avg`

## Requirements
- R1: Synchronous active-high reset clears `res_valid` and `conv_repeat` to 0 and drops any partly summed group; the next raw sample starts a new group.
- R2: With `cfg_exp` = 0, every raw sample produces `res_valid` = 1 one cycle later with `res_data` equal to the raw value, and `conv_repeat` stays 0.
- R3: With `cfg_exp` = n in 1..6, within each group of 2^n raw samples the first 2^n - 1 samples each produce a `conv_repeat` pulse and the last produces a `res_valid` pulse; the two are never high together.
- R4: `res_data` equals the sum of the group's 2^n raw samples shifted right by n, truncated.
- R5: A `cfg_exp` value of 7 is treated as 6, which gives a group of 64 samples.
- R6: `res_seq` and `res_step` carry the `ctx_seq` and `ctx_step` values present with the first sample of the group; later changes to them within the group are ignored.
- R7: `cfg_exp` is sampled only with the first raw sample of a group; changes during the group take effect from the next group.
- R8: Each output pulse lasts one cycle and appears in the cycle after the raw sample that caused it; no pulse appears without a raw sample.
- R9: A group of 64 full-scale samples (1023) yields 1023, with no wrap of the internal sum.
- R10: Idle cycles between raw samples do not change the count or the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_exp | input | 3 | Oversampling exponent (0 = pass through, 7 acts as 6) |
| raw_valid | input | 1 | Raw conversion strobe |
| raw_data | input | 10 | Raw conversion value |
| ctx_seq | input | 2 | Sequencer number of the step being converted |
| ctx_step | input | 3 | Step number within the sequencer |
| res_valid | output | 1 | Averaged result strobe, also marks the step finished |
| res_data | output | 10 | Averaged result |
| res_seq | output | 2 | Sequencer tag of the result |
| res_step | output | 3 | Step tag of the result |
| conv_repeat | output | 1 | Request to convert the same input again |

## Verification
A count that is wrong or not cleared shows at the ports as a result pulse in the wrong position within the group, visible on the first group after the fault and, at the latest, 2^n samples later. A wrong sum or a stale exponent shows as a wrong value on the next result, and a stale context shows as a wrong tag on that result. The bench sweeps every exponent, including 7, with ramp, full-scale and descending data, and disturbs the exponent, the context and the sample spacing within groups. Expected values are computed from the sum and the shift.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int AVG_MAX_EXP = 6;

  function automatic int clamp_exp(input int e, input int max_e);
    return (e > max_e) ? max_e : e;
  endfunction
endpackage

// File: rtl/avg_cfg_hold.sv
module avg_cfg_hold #(
  parameter int EXP_W  = 3,
  parameter int MAX_EXP = 6,
  parameter int SEQ_W  = 2,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [EXP_W-1:0]  cfg_exp,
  input  logic [SEQ_W-1:0]  ctx_seq,
  input  logic [STEP_W-1:0] ctx_step,
  output logic [EXP_W-1:0]  exp_eff,
  output logic [EXP_W-1:0]  exp_q,
  output logic [SEQ_W-1:0]  seq_eff,
  output logic [STEP_W-1:0] step_eff
);
  import avg_pkg::*;

  logic [EXP_W-1:0]  exp_clamped;
  logic [SEQ_W-1:0]  seq_q;
  logic [STEP_W-1:0] step_q;

  assign exp_clamped = EXP_W'(clamp_exp(int'(cfg_exp), MAX_EXP));

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= '0;
      seq_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      exp_q  <= exp_clamped;
      seq_q  <= ctx_seq;
      step_q <= ctx_step;
    end
  end

  always_comb begin
    exp_eff  = load ? exp_clamped : exp_q;
    seq_eff  = load ? ctx_seq     : seq_q;
    step_eff = load ? ctx_step    : step_q;
  end
endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
  parameter int SAMPLE_W = 10,
  parameter int EXP_W    = 3,
  parameter int MAX_EXP  = 6,
  localparam int ACC_W   = SAMPLE_W + MAX_EXP,
  localparam int CNT_W   = (MAX_EXP > 0) ? MAX_EXP : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                raw_valid,
  input  logic [SAMPLE_W-1:0] raw_data,
  input  logic [EXP_W-1:0]    exp_eff,
  output logic                first,
  output logic                last,
  output logic [ACC_W-1:0]    sum_n,
  output logic [CNT_W-1:0]    grp_cnt
);
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W:0]   final_idx;

  assign first     = (grp_cnt == '0);
  assign final_idx = ((CNT_W+1)'(1) << exp_eff) - (CNT_W+1)'(1);
  assign last      = ({1'b0, grp_cnt} == final_idx);
  assign sum_n     = (first ? '0 : acc_q) + ACC_W'(raw_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_cnt <= '0;
      acc_q   <= '0;
    end else if (raw_valid) begin
      if (last) begin
        grp_cnt <= '0;
        acc_q   <= '0;
      end else begin
        grp_cnt <= grp_cnt + CNT_W'(1);
        acc_q   <= sum_n;
      end
    end
  end
endmodule

// File: rtl/avg_emit.sv
module avg_emit #(
  parameter int SAMPLE_W = 10,
  parameter int EXP_W    = 3,
  parameter int ACC_W    = 16,
  parameter int SEQ_W    = 2,
  parameter int STEP_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                raw_valid,
  input  logic                last,
  input  logic [ACC_W-1:0]    sum_n,
  input  logic [EXP_W-1:0]    exp_eff,
  input  logic [SEQ_W-1:0]    seq_eff,
  input  logic [STEP_W-1:0]   step_eff,
  output logic                res_valid,
  output logic [SAMPLE_W-1:0] res_data,
  output logic [SEQ_W-1:0]    res_seq,
  output logic [STEP_W-1:0]   res_step,
  output logic                conv_repeat
);
  logic [ACC_W-1:0] shifted;
  assign shifted = sum_n >> exp_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      conv_repeat <= 1'b0;
      res_data    <= '0;
      res_seq     <= '0;
      res_step    <= '0;
    end else begin
      res_valid   <= raw_valid & last;
      conv_repeat <= raw_valid & ~last;
      if (raw_valid & last) begin
        res_data <= shifted[SAMPLE_W-1:0];
        res_seq  <= seq_eff;
        res_step <= step_eff;
      end
    end
  end
endmodule

// File: rtl/oversample_avg.sv
module oversample_avg #(
  parameter int SAMPLE_W = 10,
  parameter int EXP_W    = 3,
  parameter int MAX_EXP  = avg_pkg::AVG_MAX_EXP,
  parameter int SEQ_W    = 2,
  parameter int STEP_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [EXP_W-1:0]    cfg_exp,
  input  logic                raw_valid,
  input  logic [SAMPLE_W-1:0] raw_data,
  input  logic [SEQ_W-1:0]    ctx_seq,
  input  logic [STEP_W-1:0]   ctx_step,
  output logic                res_valid,
  output logic [SAMPLE_W-1:0] res_data,
  output logic [SEQ_W-1:0]    res_seq,
  output logic [STEP_W-1:0]   res_step,
  output logic                conv_repeat
);
  localparam int ACC_W = SAMPLE_W + MAX_EXP;
  localparam int CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic              first, last;
  logic [ACC_W-1:0]  sum_n;
  logic [CNT_W-1:0]  grp_cnt;
  logic [EXP_W-1:0]  exp_eff, exp_q;
  logic [SEQ_W-1:0]  seq_eff;
  logic [STEP_W-1:0] step_eff;

  avg_cfg_hold #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .SEQ_W(SEQ_W), .STEP_W(STEP_W)) u_cfg (
    .clk(clk), .rst(rst), .load(raw_valid & first), .cfg_exp(cfg_exp),
    .ctx_seq(ctx_seq), .ctx_step(ctx_step), .exp_eff(exp_eff), .exp_q(exp_q),
    .seq_eff(seq_eff), .step_eff(step_eff)
  );

  avg_accum #(.SAMPLE_W(SAMPLE_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_acc (
    .clk(clk), .rst(rst), .raw_valid(raw_valid), .raw_data(raw_data),
    .exp_eff(exp_eff), .first(first), .last(last), .sum_n(sum_n), .grp_cnt(grp_cnt)
  );

  avg_emit #(.SAMPLE_W(SAMPLE_W), .EXP_W(EXP_W), .ACC_W(ACC_W), .SEQ_W(SEQ_W), .STEP_W(STEP_W)) u_emit (
    .clk(clk), .rst(rst), .raw_valid(raw_valid), .last(last), .sum_n(sum_n),
    .exp_eff(exp_eff), .seq_eff(seq_eff), .step_eff(step_eff),
    .res_valid(res_valid), .res_data(res_data), .res_seq(res_seq),
    .res_step(res_step), .conv_repeat(conv_repeat)
  );
endmodule

// File: rtl/oversample_avg_chk.sv
module oversample_avg_chk #(
  parameter int SAMPLE_W = 10,
  parameter int EXP_W    = 3,
  parameter int MAX_EXP  = 6,
  parameter int CNT_W    = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [EXP_W-1:0]    cfg_exp,
  input logic                raw_valid,
  input logic [SAMPLE_W-1:0] raw_data,
  input logic                res_valid,
  input logic [SAMPLE_W-1:0] res_data,
  input logic                conv_repeat,
  input logic [CNT_W-1:0]    grp_cnt,
  input logic [EXP_W-1:0]    exp_q
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst) !(res_valid && conv_repeat)); // R3
  AST_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst) (res_valid || conv_repeat) |-> $past(raw_valid)); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    ($past(raw_valid) && $past(cfg_exp) == '0 && $past(grp_cnt) == '0 && !$past(rst))
      |-> (res_valid && !conv_repeat && res_data == $past(raw_data))); // R2
  AST_EXP_HELD: assert property (@(posedge clk) disable iff (rst)
    (grp_cnt != '0 && $past(grp_cnt) != '0) |-> $stable(exp_q)); // R7
  AST_EXP_CLAMP: assert property (@(posedge clk) disable iff (rst) int'(exp_q) <= MAX_EXP); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(raw_valid) && !$past(rst)) |-> ($stable(grp_cnt) && !res_valid && !conv_repeat)); // R10
endmodule

bind oversample_avg oversample_avg_chk #(
  .SAMPLE_W(SAMPLE_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_exp(cfg_exp), .raw_valid(raw_valid), .raw_data(raw_data),
  .res_valid(res_valid), .res_data(res_data), .conv_repeat(conv_repeat),
  .grp_cnt(grp_cnt), .exp_q(exp_q)
);

// File: tb/sim_oversample_avg.sv
module sim_oversample_avg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_exp = '0;
  logic       raw_valid = 1'b0;
  logic [9:0] raw_data = '0;
  logic [1:0] ctx_seq = '0;
  logic [2:0] ctx_step = '0;
  logic       res_valid, conv_repeat;
  logic [9:0] res_data;
  logic [1:0] res_seq;
  logic [2:0] res_step;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  oversample_avg u0 (
    .clk(clk), .rst(rst), .cfg_exp(cfg_exp), .raw_valid(raw_valid), .raw_data(raw_data),
    .ctx_seq(ctx_seq), .ctx_step(ctx_step), .res_valid(res_valid), .res_data(res_data),
    .res_seq(res_seq), .res_step(res_step), .conv_repeat(conv_repeat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pat_val(input int pat, input int i);
    case (pat)
      0: return (i * 37 + 5) % 1024;
      1: return 1023;
      default: return (1023 - i * 13) % 1024;
    endcase
  endfunction

  // One raw sample: drive at a falling edge, captured at the rising edge,
  // outputs inspected at the following falling edge.
  task automatic push(input int d, input int e_cfg, input int sq, input int st);
    raw_data  = 10'(d);
    cfg_exp   = 3'(e_cfg);
    ctx_seq   = 2'(sq);
    ctx_step  = 3'(st);
    raw_valid = 1'b1;
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic group(input int cfg, input int pat, input int sq, input int st, input bit perturb);
    int e = (cfg > 6) ? 6 : cfg;
    int n = 1 << e;
    int sum = 0;
    for (int i = 0; i < n; i++) begin
      int d = pat_val(pat, i);
      int c = (i == 0 || !perturb) ? cfg : (cfg + 3) % 8;
      int s = (i == 0 || !perturb) ? sq : (sq + 1) % 4;
      int t = (i == 0 || !perturb) ? st : (st + 5) % 8;
      sum += d;
      if (perturb && (i % 2 == 1)) begin
        @(negedge clk);
        chk(!res_valid && !conv_repeat, "R10 idle gap output", int'(res_valid), 0);
      end
      push(d, c, s, t);
      if (i < n - 1) begin
        chk(conv_repeat && !res_valid, (perturb ? "R7 repeat within group" : "R3 repeat pulse"),
            int'(conv_repeat), 1);
      end else begin
        chk(res_valid && !conv_repeat, (cfg == 0 ? "R2 pass-through strobe" :
            (cfg == 7 ? "R5 clamped group length" : "R3 result pulse")), int'(res_valid), 1);
        chk(int'(res_data) == (sum >> e), (pat == 1 && e == 6) ? "R9 full-scale result" : "R4 averaged value",
            int'(res_data), sum >> e);
        chk(int'(res_seq) == sq && int'(res_step) == st, "R6 context tag",
            int'(res_seq) * 8 + int'(res_step), sq * 8 + st);
      end
    end
    @(negedge clk);
    chk(!res_valid && !conv_repeat, "R8 single-cycle pulse", int'(res_valid) + int'(conv_repeat), 0);
  endtask

  initial begin
    // R1: reset with stimulus present
    raw_valid = 1'b1;
    raw_data  = 10'd77;
    repeat (3) @(negedge clk);
    raw_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(!res_valid && !conv_repeat, "R1 reset outputs", int'(res_valid) + int'(conv_repeat), 0);

    // R2: pass-through, several values
    for (int k = 0; k < 8; k++) begin
      push(k * 131 % 1024, 0, k % 4, k % 8);
      chk(res_valid && !conv_repeat && int'(res_data) == k * 131 % 1024, "R2 pass-through value",
          int'(res_data), k * 131 % 1024);
    end
    @(negedge clk);

    // R3 R4 R5 R9: sweep every exponent and data pattern
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 3; p++)
        group(c, p, (c + p) % 4, (c * 3 + p) % 8, 1'b0);

    // R6 R7 R10: disturb exponent, context and spacing inside groups
    for (int c = 1; c < 8; c++)
      group(c, 0, c % 4, c % 8, 1'b1);

    // R1: reset mid-group drops the partial sum
    push(900, 3, 1, 1);
    push(900, 3, 1, 1);
    push(900, 3, 1, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    push(10, 1, 2, 4);
    chk(conv_repeat && !res_valid, "R1 fresh group after reset", int'(conv_repeat), 1);
    push(21, 1, 2, 4);
    chk(res_valid && int'(res_data) == 15, "R1 sum after reset", int'(res_data), 15);
    @(negedge clk);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule